// File: doc/BRIEF.md
# ECC Event Capture Unit

This unit sits beside the ECC decoder of one memory port and keeps a record of the most recent ECC event that software asked to hear about. Every cycle it sees the address, master ID, attributes and data of the access on the port. It also sees two one-cycle pulses from the decoder: one for a single-bit error that was corrected and one for an error that could not be corrected. When a pulse arrives and its report enable is set, the access details are copied into read-only capture registers and a sticky status flag for that event kind is set.

Software reaches the unit through a small word-addressed register port. Through it, software sets the two report enables, reads the capture registers, and clears each status flag by writing 1 to its bit. An interrupt output is active while any flag is set whose report enable is also set.

Top module: `ecc_event_capture`

## Requirements
- R1: After reset, and during reset, every register reads as zero, both status flags are 0 and `irq` is 0.
- R2: On an enabled event, the address (offset 2), the master ID and attributes (offset 3: master ID in bits 3:0, attributes in bits 15:8), and the data (offset 4) of the access on that cycle are all loaded on the same clock edge. They can be read from the next cycle.
- R3: An enabled corrected event sets status bit 0. An enabled uncorrectable event sets status bit 1. Both flags stay set until software clears them.
- R4: An event whose report enable is 0 loads no capture register and sets no flag.
- R5: Each new enabled event overwrites the previous capture, so the registers always hold the latest enabled event.
- R6: If both pulses arrive in the same cycle, the capture is tagged as uncorrectable: offset 3 bit 31 is 1 when the captured event was uncorrectable and 0 when it was corrected. Each flag whose enable is set is raised.
- R7: Writing offset 1 clears each status flag whose write-data bit (bit 0 or bit 1) is 1. Bits written as 0 leave their flags unchanged.
- R8: If a clear and a new event for the same flag arrive in the same cycle, the flag stays set.
- R9: `irq` is 1 exactly when some status flag is set and the report enable for that flag is also set.
- R10: Writes to offsets 2, 3 and 4 are ignored, and the captured values are unchanged afterwards.
- R11: Offset 0 is the configuration word, readable and writable. Bit 0 enables corrected-event reports and bit 1 enables uncorrectable-event reports. Offset 1 reads the flags in bits 1:0. Unmapped offsets read zero. Reads are combinational on `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ev_single | input | 1 | Decoder pulse: single-bit error corrected |
| ev_fatal | input | 1 | Decoder pulse: uncorrectable error |
| ev_addr | input | 32 | Address of the current access |
| ev_mid | input | MID_W | Master ID of the current access |
| ev_attr | input | ATTR_W | Attributes of the current access |
| ev_data | input | DATA_W | Data of the current access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
Table-driven stimulus tries each combination of the two pulses under each combination of the two report enables. This separates four cases:
- capture with one flag;
- capture with both flags and the uncorrectable tag;
- a suppressed event, which must leave the previous address in place;
- a quiet cycle.

Each access uses distinct address, ID, attribute and data values, so a field taken from the wrong cycle or left unloaded shows up. Directed steps then check:
- partial write-1 clears;
- a clear that collides with a new event;
- writes aimed at the capture registers;
- interrupt masking by the enables after a flag is already set.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

    localparam int REG_AW   = 3;
    localparam int REG_DW   = 32;
    localparam int ADDR_W   = 32;
    localparam int ATTR_LSB = 8;
    localparam int KIND_BIT = 31;

    typedef enum logic [REG_AW-1:0] {
        OFS_CFG  = 3'd0,
        OFS_STAT = 3'd1,
        OFS_ADDR = 3'd2,
        OFS_INFO = 3'd3,
        OFS_DATA = 3'd4
    } reg_ofs_e;

    // bit 1: uncorrectable, bit 0: corrected
    typedef struct packed {
        logic fatal;
        logic single;
    } ev_pair_t;

endpackage

// File: rtl/ecc_cap_regif.sv
module ecc_cap_regif
    import ecc_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  ev_pair_t          flags,
    input  logic [REG_DW-1:0] cap_addr,
    input  logic [REG_DW-1:0] cap_info,
    input  logic [REG_DW-1:0] cap_data,
    output ev_pair_t          cfg_en,
    output ev_pair_t          clr_req,
    output logic [REG_DW-1:0] reg_rdata
);

    typedef struct packed {
        logic [REG_DW-1:0] cfg_word;
    } regif_st_t;

    regif_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        clr_req = '0;
        if (reg_wr) begin
            case (reg_ofs_e'(reg_addr))
                OFS_CFG:  st_d.cfg_word = reg_wdata;
                OFS_STAT: clr_req       = ev_pair_t'(reg_wdata[1:0]);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_en = ev_pair_t'(st_q.cfg_word[1:0]);

    always_comb begin
        case (reg_ofs_e'(reg_addr))
            OFS_CFG:  reg_rdata = st_q.cfg_word;
            OFS_STAT: reg_rdata = {{(REG_DW-2){1'b0}}, flags};
            OFS_ADDR: reg_rdata = cap_addr;
            OFS_INFO: reg_rdata = cap_info;
            OFS_DATA: reg_rdata = cap_data;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecc_cap_status.sv
module ecc_cap_status
    import ecc_cap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ev_pair_t hit,
    input  ev_pair_t clr_req,
    output ev_pair_t flags
);

    typedef struct packed {
        ev_pair_t flags;
    } stat_st_t;

    stat_st_t st_d, st_q;

    // a new event outranks a clear of the same bit
    always_comb begin
        st_d       = st_q;
        st_d.flags = ev_pair_t'((st_q.flags & ~clr_req) | hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;

endmodule

// File: rtl/ecc_cap_store.sv
module ecc_cap_store
    import ecc_cap_pkg::*;
#(
    parameter int MID_W  = 4,
    parameter int ATTR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ev_pair_t          hit,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [MID_W-1:0]  ev_mid,
    input  logic [ATTR_W-1:0] ev_attr,
    input  logic [DATA_W-1:0] ev_data,
    output logic [REG_DW-1:0] cap_addr,
    output logic [REG_DW-1:0] cap_info,
    output logic [REG_DW-1:0] cap_data
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [MID_W-1:0]  mid;
        logic [ATTR_W-1:0] attr;
        logic [DATA_W-1:0] data;
        logic              kind;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit.single || hit.fatal) begin
            st_d.addr = ev_addr;
            st_d.mid  = ev_mid;
            st_d.attr = ev_attr;
            st_d.data = ev_data;
            st_d.kind = hit.fatal;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cap_info                       = '0;
        cap_info[MID_W-1:0]            = st_q.mid;
        cap_info[ATTR_LSB +: ATTR_W]   = st_q.attr;
        cap_info[KIND_BIT]             = st_q.kind;
    end

    assign cap_addr = REG_DW'(st_q.addr);
    assign cap_data = REG_DW'(st_q.data);

endmodule

// File: rtl/ecc_event_capture.sv
module ecc_event_capture
    import ecc_cap_pkg::*;
#(
    parameter int MID_W  = 4,
    parameter int ATTR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_single,
    input  logic              ev_fatal,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [MID_W-1:0]  ev_mid,
    input  logic [ATTR_W-1:0] ev_attr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq
);

    ev_pair_t          cfg_en;
    ev_pair_t          clr_req;
    ev_pair_t          flags;
    ev_pair_t          hit;
    logic [REG_DW-1:0] cap_addr;
    logic [REG_DW-1:0] cap_info;
    logic [REG_DW-1:0] cap_data;

    always_comb begin
        hit.single = ev_single & cfg_en.single;
        hit.fatal  = ev_fatal  & cfg_en.fatal;
    end

    ecc_cap_regif i_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .flags     (flags),
        .cap_addr  (cap_addr),
        .cap_info  (cap_info),
        .cap_data  (cap_data),
        .cfg_en    (cfg_en),
        .clr_req   (clr_req),
        .reg_rdata (reg_rdata)
    );

    ecc_cap_status i_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr_req (clr_req),
        .flags   (flags)
    );

    ecc_cap_store #(
        .MID_W  (MID_W),
        .ATTR_W (ATTR_W),
        .DATA_W (DATA_W)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .ev_addr  (ev_addr),
        .ev_mid   (ev_mid),
        .ev_attr  (ev_attr),
        .ev_data  (ev_data),
        .cap_addr (cap_addr),
        .cap_info (cap_info),
        .cap_data (cap_data)
    );

    assign irq = |(flags & cfg_en);

endmodule

// File: rtl/ecc_cap_checker.sv
module ecc_cap_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_single,
    input logic        ev_fatal,
    input logic [31:0] ev_addr,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [1:0]  cfg_en,
    input logic [1:0]  flags,
    input logic [31:0] cap_addr,
    input logic [31:0] cap_info,
    input logic        irq
);

    logic any_hit;
    logic clr0;
    assign any_hit = (ev_single & cfg_en[0]) | (ev_fatal & cfg_en[1]);
    assign clr0    = reg_wr && (reg_addr == 3'd1) && reg_wdata[0];

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |=> cap_addr == $past(ev_addr));

    p_single_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_single && cfg_en[0]) |=> flags[0]);

    p_fatal_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fatal && cfg_en[1]) |=> flags[1]);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |=> $stable(cap_addr) && $stable(cap_info));

    p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fatal && cfg_en[1]) |=> cap_info[31]);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !clr0) |=> flags[0]);

    p_quiet_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 2'b00) |-> !irq);

endmodule

bind ecc_event_capture ecc_cap_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_single (ev_single),
    .ev_fatal  (ev_fatal),
    .ev_addr   (ev_addr),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cfg_en    (cfg_en),
    .flags     (flags),
    .cap_addr  (cap_addr),
    .cap_info  (cap_info),
    .irq       (irq)
);

// File: tb/test_ecc_event_capture.sv
module test_ecc_event_capture;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_single = 1'b0;
    logic        ev_fatal = 1'b0;
    logic [31:0] ev_addr = '0;
    logic [3:0]  ev_mid = '0;
    logic [7:0]  ev_attr = '0;
    logic [31:0] ev_data = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ecc_event_capture i_ecc_event_capture (
        .clk(clk), .rst_n(rst_n), .ev_single(ev_single), .ev_fatal(ev_fatal),
        .ev_addr(ev_addr), .ev_mid(ev_mid), .ev_attr(ev_attr), .ev_data(ev_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  cfg;
        logic        sgl;
        logic        fat;
        logic [31:0] addr;
        logic [1:0]  eflags;
        logic [31:0] eaddr;
        logic        ekind;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{2'd3, 1'b1, 1'b0, 32'h8000_1234, 2'b01, 32'h8000_1234, 1'b0},
        '{2'd3, 1'b0, 1'b1, 32'h0000_ABC8, 2'b10, 32'h0000_ABC8, 1'b1},
        '{2'd1, 1'b0, 1'b1, 32'h1111_2223, 2'b00, 32'h0000_ABC8, 1'b1},
        '{2'd2, 1'b1, 1'b0, 32'h2222_3334, 2'b00, 32'h0000_ABC8, 1'b1},
        '{2'd3, 1'b1, 1'b1, 32'hDEAD_BEEF, 2'b11, 32'hDEAD_BEEF, 1'b1},
        '{2'd1, 1'b1, 1'b1, 32'h0F0F_F0F1, 2'b01, 32'h0F0F_F0F1, 1'b0},
        '{2'd3, 1'b0, 1'b0, 32'h7777_7777, 2'b00, 32'h0F0F_F0F1, 1'b0}
    };

    function automatic logic [31:0] info_of(input logic [31:0] a, input logic k);
        return {k, 15'd0, a[11:4], 4'd0, a[3:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic pulse(input logic s, input logic f, input logic [31:0] a);
        @(negedge clk);
        ev_single = s; ev_fatal = f; ev_addr = a;
        ev_mid = a[3:0]; ev_attr = a[11:4]; ev_data = a ^ 32'h5A5A_5A5A;
        @(negedge clk);
        ev_single = 1'b0; ev_fatal = 1'b0; ev_addr = ~a; ev_data = a;
        ev_mid = ~a[3:0]; ev_attr = ~a[11:4];
    endtask

    task automatic check_zero(input string tag);
        logic [31:0] v;
        for (int o = 0; o < 5; o++) begin
            rd(3'(o), v);
            chk(tag, v, 32'h0);
        end
        chk(tag, 32'(irq), 32'h0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        check_zero("R1 during reset");
        rst_n = 1'b1;
        check_zero("R1 after reset");

        // table walk: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            wr(3'd1, 32'h3);
            wr(3'd0, 32'(VEC[i].cfg));
            pulse(VEC[i].sgl, VEC[i].fat, VEC[i].addr);
            rd(3'd1, v);  chk($sformatf("R3/R4 flags v%0d", i), v, 32'(VEC[i].eflags));
            rd(3'd2, v);  chk($sformatf("R2/R5 addr v%0d", i), v, VEC[i].eaddr);
            rd(3'd3, v);  chk($sformatf("R2/R6 info v%0d", i), v, info_of(VEC[i].eaddr, VEC[i].ekind));
            rd(3'd4, v);  chk($sformatf("R2 data v%0d", i), v, VEC[i].eaddr ^ 32'h5A5A_5A5A);
            chk($sformatf("R9 irq v%0d", i), 32'(irq), 32'(|(VEC[i].eflags & VEC[i].cfg)));
        end

        // R11: configuration word readback and unmapped offset
        rd(3'd0, v);  chk("R11 cfg readback", v, 32'h3);
        rd(3'd7, v);  chk("R11 unmapped", v, 32'h0);

        // R10: writes to capture registers ignored
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd2, v);  chk("R10 addr kept", v, 32'h0F0F_F0F1);
        rd(3'd3, v);  chk("R10 info kept", v, info_of(32'h0F0F_F0F1, 1'b0));
        rd(3'd4, v);  chk("R10 data kept", v, 32'h0F0F_F0F1 ^ 32'h5A5A_5A5A);
        rd(3'd1, v);  chk("R10 status kept", v, 32'h0);

        // R7: per-bit write-1 clear
        pulse(1'b1, 1'b1, 32'h3333_4445);
        rd(3'd1, v);  chk("R7 both set", v, 32'h3);
        wr(3'd1, 32'h1);
        rd(3'd1, v);  chk("R7 clear bit0 only", v, 32'h2);
        wr(3'd1, 32'h0);
        rd(3'd1, v);  chk("R7 write zero no effect", v, 32'h2);
        chk("R9 irq fatal", 32'(irq), 32'h1);

        // R9: enables mask the interrupt, flags stay (R3)
        wr(3'd0, 32'h1);
        chk("R9 masked irq", 32'(irq), 32'h0);
        rd(3'd1, v);  chk("R3 sticky under mask", v, 32'h2);
        wr(3'd0, 32'h2);
        chk("R9 unmasked irq", 32'(irq), 32'h1);

        // R8: clear collides with new event
        wr(3'd0, 32'h3);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h1;
        ev_single = 1'b1; ev_addr = 32'h4444_5556;
        ev_mid = 4'h6; ev_attr = 8'h55; ev_data = 32'h4444_5556 ^ 32'h5A5A_5A5A;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; ev_single = 1'b0;
        rd(3'd1, v);  chk("R8 set beats clear", v, 32'h3);
        wr(3'd1, 32'h3);
        rd(3'd1, v);  chk("R7 clear both", v, 32'h0);
        chk("R9 irq idle", 32'(irq), 32'h0);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        check_zero("R1 mid-run reset");
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule